// File: doc/BRIEF.md
# I2C Master with Empty-Queue Bus Hold and Abort

This block is a single-master I2C controller. Software writes command words into a small queue. Each word carries one byte, a direction, a stop request and a repeated-start request. The sequencer turns each word into SCL and SDA activity on open-drain style outputs. The outputs are asserted to pull a line low and released to let it float high.

When the queue runs dry after a command that asked for no stop, a build-time option decides the outcome. With the option on, the controller parks the bus with SCL pulled low until more commands arrive. With the option off, it closes the transfer with a STOP.

A parked bus can be released by a self-clearing abort request. The abort sends a STOP, empties the queue and records a transfer-abort flag. Clearing the enable bit is refused while the bus is parked, so software has to abort or feed the controller before it can turn the controller off. The SCL high and low times are set in system clock cycles by two registers.

Top module: `i2c_hold_master`

## Requirements
- R1: A command word is written at register offset 1. Bits 7:0 hold the byte, bit 8 selects a read (1) or a write (0), bit 9 requests a STOP after the byte, and bit 10 requests a repeated START before it. Written bytes go out MSB first, followed by a ninth clock on which SDA is released for the slave's acknowledge.
- R2: An enabled, idle controller with a non-empty queue generates a START: SDA falls while SCL is high. After the byte of a command with bit 9 set, it generates a STOP: SDA rises while SCL is high. It then returns to idle.
- R3: Every SCL low time outside the bus hold lasts exactly the low-count register (offset 5) in clock cycles. Every SCL high time that contains no START lasts exactly the high-count register (offset 4).
- R4: SDA driven by the controller changes while SCL is high only to form a START (falling) or a STOP (rising).
- R5: For a read command, eight bits are sampled MSB first, and the byte is readable at offset 6. On the ninth clock the controller drives an ACK (SDA low), unless bit 9 is set, in which case it leaves SDA released (NACK).
- R6: A command with bit 10 set is preceded by a repeated START, without a STOP in between.
- R7: With the hold option on, when the queue is empty after a byte whose command had bit 9 clear, SCL stays low and no STOP is sent. While this lasts, bit 13 of the raw status register (offset 2) reads 1 and the activity bit reads 1.
- R8: A command written during the hold leaves SCL low for exactly low-count + 1 further cycles. The transfer then continues with that command's byte.
- R9: Setting bit 1 of the control register (offset 0) aborts. A parked bus gets a STOP, and an idle controller aborts at once. The queue is emptied, bit 6 of the raw status register is set, and bit 1 clears itself when the controller is idle again.
- R10: Bit 0 of the control register enables the controller. Writing it to 0 while the bus is held leaves it at 1. Otherwise it takes effect, and a disabled controller starts no new transfer.
- R11: The status register (offset 3) shows bit 0 = transfer in progress and bit 2 = queue empty. It reads 0x0004 after reset.
- R12: With the hold option off, a queue that runs dry after a byte without a stop request ends in a STOP, and bit 13 of the raw status register never reads 1.
- R13: Writing 1 to bit 6 of the raw status register clears the abort flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume three things about the inputs. The timing registers hold values of at least 1 and are not rewritten during a transfer. The abort bit is written only while the controller is enabled or idle. No slave stretches SCL, since the controller never reads SCL back.

The bench changes the high and low counts only between transfers, always with values of 2 or more. Its slave model touches SDA only while SCL is low and lets go of the line once its scripted read bytes are sent, so the controller's STOP conditions can be seen on the shared line.

// File: rtl/i2chm_pkg.sv
// Shared types for the I2C hold master: the command word layout,
// the bus sequencer states and the register offsets.
package i2chm_pkg;
    localparam int CMD_W = 11;

    // Command word: bit 10 repeated START, bit 9 STOP, bit 8 read, 7:0 byte
    typedef struct packed {
        logic       rs;
        logic       stop;
        logic       rd;
        logic [7:0] data;
    } cmd_t;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_RS_LO, S_RS_HI, S_LOW, S_HIGH,
        S_HOLD, S_SP_LO, S_SP_HI, S_SP_FREE
    } bus_st_t;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CMD  = 3'd1;
    localparam logic [2:0] A_RAW  = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_SHI  = 3'd4;
    localparam logic [2:0] A_SLO  = 3'd5;
    localparam logic [2:0] A_RXD  = 3'd6;

    localparam int RAW_HOLD_BIT = 13;
    localparam int RAW_ABRT_BIT = 6;
endpackage

// File: rtl/i2chm_fifo.sv
// Command queue: a power-of-two deep FIFO with show-ahead output.
// Assumes DEPTH >= 2 and a power of two. A push into a full queue is
// dropped. Flush wins over push and pop in the same cycle.
module i2chm_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          push_ok, pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign dout    = mem[rp];

    // Storage write port
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end
endmodule

// File: rtl/i2chm_seq.sv
// Bus sequencer: walks START, nine-clock byte slots, repeated START,
// STOP and the empty-queue hold, timed by the high/low count inputs.
// Assumes counts >= 1 that stay stable during a transfer and an
// unstretched SCL. Abort is acted on at a byte boundary, in the hold
// or in idle.
module i2chm_seq
    import i2chm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter bit HOLD_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             abort_req,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] lcnt,
    input  logic             fifo_empty,
    input  cmd_t             fifo_dout,
    input  logic             sda_in,
    output logic             fifo_pop,
    output logic             scl_low,
    output logic             sda_low,
    output logic             busy,
    output logic             holding,
    output logic             abort_done,
    output logic [7:0]       rx_byte
);
    bus_st_t          st, nxt;
    logic [CNT_W-1:0] tmr;
    logic [3:0]       bitn;
    cmd_t             cur;
    logic [7:0]       rx_sh;
    logic             aborting;
    logic             ld_hi, ld_lo, tdone, drv;

    assign tdone   = (tmr == '0);
    assign busy    = (st != S_IDLE);
    assign holding = (st == S_HOLD);
    assign rx_byte = rx_sh;

    // Next state, queue pop and timer reload selection
    always_comb begin
        nxt        = st;
        fifo_pop   = 1'b0;
        ld_hi      = 1'b0;
        ld_lo      = 1'b0;
        abort_done = 1'b0;
        case (st)
            S_IDLE: begin
                if (abort_req) begin
                    abort_done = 1'b1;
                end else if (en && !fifo_empty) begin
                    fifo_pop = 1'b1;
                    nxt      = S_START;
                    ld_hi    = 1'b1;
                end
            end
            S_START:  if (tdone) begin nxt = S_LOW;   ld_lo = 1'b1; end
            S_RS_LO:  if (tdone) begin nxt = S_RS_HI; ld_hi = 1'b1; end
            S_RS_HI:  if (tdone) begin nxt = S_START; ld_hi = 1'b1; end
            S_LOW:    if (tdone) begin nxt = S_HIGH;  ld_hi = 1'b1; end
            S_HIGH: begin
                if (tdone) begin
                    if (bitn != 4'd8) begin
                        nxt = S_LOW; ld_lo = 1'b1;
                    end else if (cur.stop || abort_req) begin
                        nxt = S_SP_LO; ld_lo = 1'b1;
                    end else if (!fifo_empty) begin
                        fifo_pop = 1'b1;
                        nxt      = fifo_dout.rs ? S_RS_LO : S_LOW;
                        ld_lo    = 1'b1;
                    end else if (HOLD_EN && en) begin
                        nxt = S_HOLD;
                    end else begin
                        nxt = S_SP_LO; ld_lo = 1'b1;
                    end
                end
            end
            S_HOLD: begin
                if (abort_req) begin
                    nxt = S_SP_LO; ld_lo = 1'b1;
                end else if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    nxt      = fifo_dout.rs ? S_RS_LO : S_LOW;
                    ld_lo    = 1'b1;
                end
            end
            S_SP_LO:  if (tdone) begin nxt = S_SP_HI;   ld_hi = 1'b1; end
            S_SP_HI:  if (tdone) begin nxt = S_SP_FREE; ld_hi = 1'b1; end
            S_SP_FREE: begin
                if (tdone) begin
                    nxt        = S_IDLE;
                    abort_done = aborting;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State, phase timer, bit slot, current command and receive shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            tmr      <= '0;
            bitn     <= '0;
            cur      <= '0;
            rx_sh    <= '0;
            aborting <= 1'b0;
        end else begin
            st <= nxt;
            if (ld_hi)           tmr <= (hcnt == '0) ? '0 : hcnt - 1'b1;
            else if (ld_lo)      tmr <= (lcnt == '0) ? '0 : lcnt - 1'b1;
            else if (!tdone)     tmr <= tmr - 1'b1;
            if (fifo_pop) begin
                cur  <= fifo_dout;
                bitn <= '0;
            end else if (st == S_HIGH && tdone && bitn != 4'd8) begin
                bitn <= bitn + 1'b1;
                if (cur.rd) rx_sh <= {rx_sh[6:0], sda_in};
            end
            if (nxt == S_SP_LO && st != S_SP_LO) aborting <= abort_req;
            else if (st == S_IDLE)              aborting <= 1'b0;
        end
    end

    // SDA level wanted during the current bit slot
    always_comb begin
        if (bitn == 4'd8) drv = cur.rd && !cur.stop;
        else              drv = !cur.rd && !cur.data[3'd7 - bitn[2:0]];
    end

    // Line drivers decoded from the sequencer state
    always_comb begin
        scl_low = (st == S_RS_LO) || (st == S_LOW) || (st == S_HOLD) || (st == S_SP_LO);
        case (st)
            S_START, S_SP_LO, S_SP_HI: sda_low = 1'b1;
            S_LOW, S_HIGH:             sda_low = drv;
            default:                   sda_low = 1'b0;
        endcase
    end

    // R4
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
        |-> ((st == S_START && sda_low) || (st == S_SP_FREE && !sda_low)));
endmodule

// File: rtl/i2c_hold_master.sv
// I2C master top: register file, command queue and bus sequencer.
// Assumes the register bus writes one register per cycle and that
// software keeps the SCL counts >= 1. Read data is combinational.
module i2c_hold_master
    import i2chm_pkg::*;
#(
    parameter int         DEPTH   = 4,
    parameter int         CNT_W   = 8,
    parameter bit         HOLD_EN = 1'b1,
    parameter logic [7:0] HI_RST  = 8'd10,
    parameter logic [7:0] LO_RST  = 8'd10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        sda_in,
    output logic        scl_low_o,
    output logic        sda_low_o
);
    logic             ctrl_en, ctrl_abort, abrt_flag;
    logic [CNT_W-1:0] hcnt, lcnt;
    logic             q_push, q_pop, q_empty, q_full;
    logic [CMD_W-1:0] q_dout;
    cmd_t             q_cmd;
    logic             busy, holding, abort_done;
    logic [7:0]       rx_byte;

    assign q_push = reg_wr && (reg_addr == A_CMD);
    assign q_cmd  = q_dout;

    i2chm_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(q_push), .pop(q_pop), .flush(abort_done),
        .din(reg_wdata[CMD_W-1:0]), .dout(q_dout), .empty(q_empty), .full(q_full)
    );

    i2chm_seq #(.CNT_W(CNT_W), .HOLD_EN(HOLD_EN)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .abort_req(ctrl_abort),
        .hcnt(hcnt), .lcnt(lcnt), .fifo_empty(q_empty), .fifo_dout(q_cmd),
        .sda_in(sda_in), .fifo_pop(q_pop), .scl_low(scl_low_o), .sda_low(sda_low_o),
        .busy(busy), .holding(holding), .abort_done(abort_done), .rx_byte(rx_byte)
    );

    // Control, abort flag and timing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en    <= 1'b0;
            ctrl_abort <= 1'b0;
            abrt_flag  <= 1'b0;
            hcnt       <= CNT_W'(HI_RST);
            lcnt       <= CNT_W'(LO_RST);
        end else begin
            if (abort_done) ctrl_abort <= 1'b0;
            if (reg_wr) begin
                case (reg_addr)
                    A_CTRL: begin
                        if (reg_wdata[0] || !holding) ctrl_en <= reg_wdata[0];
                        if (reg_wdata[1])             ctrl_abort <= 1'b1;
                    end
                    A_RAW:   if (reg_wdata[RAW_ABRT_BIT]) abrt_flag <= 1'b0;
                    A_SHI:   hcnt <= reg_wdata[CNT_W-1:0];
                    A_SLO:   lcnt <= reg_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (abort_done) abrt_flag <= 1'b1;
        end
    end

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[1:0] = {ctrl_abort, ctrl_en};
            A_RAW: begin
                reg_rdata[RAW_HOLD_BIT] = holding;
                reg_rdata[RAW_ABRT_BIT] = abrt_flag;
            end
            A_STAT: begin
                reg_rdata[0] = busy;
                reg_rdata[2] = q_empty;
            end
            A_SHI:   reg_rdata = 16'(hcnt);
            A_SLO:   reg_rdata = 16'(lcnt);
            A_RXD:   reg_rdata = 16'(rx_byte);
            default: reg_rdata = '0;
        endcase
    end

    // R10
    hold_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        holding |-> ctrl_en);

    // R9
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_abort) |-> (!busy && q_empty && abrt_flag));

    // R12
    no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD_EN == 1'b0) |-> !holding);

    // R11
    empty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !q_empty);
endmodule

// File: tb/sim_i2c_hold_master.sv
module sim_i2c_hold_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 1'b0, wr1 = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] rdata0, rdata1;
    logic        scl_low0, sda_low0, scl_low1, sda_low1;
    logic        slv_pull = 1'b0;
    logic        sda_bus0, sda_in1;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // monitor and slave model state
    int   nstart, nstop, nbytes, bad_lo, bad_hi, lo_len, hi_len;
    int   bitc, byte_no, slv_nread, nstop1;
    int   hexp, lexp;
    bit   tchk, seen_st, rw;
    logic prev_scl, prev_sda, prev1_scl, prev1_sda;
    logic [7:0] shreg, slv_base;
    logic [7:0] byte_log [64];
    logic       ack_log [64];

    assign sda_bus0 = !(sda_low0 || slv_pull);
    assign sda_in1  = !sda_low1;

    always #4 clk = !clk;

    i2c_hold_master #(.HOLD_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr0), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata0), .sda_in(sda_bus0), .scl_low_o(scl_low0), .sda_low_o(sda_low0));

    i2c_hold_master #(.HOLD_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr1), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata1), .sda_in(sda_in1), .scl_low_o(scl_low1), .sda_low_o(sda_low1));

    // Bus monitor, pulse timer and scripted slave, sampled away from the edge
    always @(negedge clk) begin
        logic scl, sda, s1, d1;
        scl = !scl_low0; sda = sda_bus0;
        s1 = !scl_low1;  d1 = sda_in1;
        if (!rst_n) begin
            prev_scl = 1; prev_sda = 1; prev1_scl = 1; prev1_sda = 1;
        end else begin
            if (scl && prev_scl && prev_sda && !sda) begin
                nstart++; bitc = 0; byte_no = 0; seen_st = 1; slv_pull = 0;
            end
            if (scl && prev_scl && !prev_sda && sda) begin
                nstop++; slv_pull = 0;
            end
            if (scl && !prev_scl) begin
                if (tchk && lo_len != lexp) bad_lo++;
                if (bitc < 8) begin
                    shreg = {shreg[6:0], sda}; bitc++;
                end else begin
                    byte_log[nbytes & 63] = shreg;
                    ack_log[nbytes & 63]  = sda;
                    nbytes++;
                    if (byte_no == 0) rw = shreg[0];
                    byte_no++; bitc = 0;
                end
                hi_len = 0;
            end
            if (!scl && prev_scl) begin
                if (tchk && !seen_st && hi_len != hexp) bad_hi++;
                seen_st = 0; lo_len = 0;
                if (bitc == 8) slv_pull = (byte_no == 0) || !rw;
                else if (rw && byte_no >= 1 && byte_no <= slv_nread) begin
                    logic [7:0] p;
                    p = slv_base + 8'(byte_no - 1) * 8'h13;
                    slv_pull = !p[3'd7 - 3'(bitc)];
                end else slv_pull = 0;
            end
            if (scl) hi_len++; else lo_len++;
            if (s1 && prev1_scl && !prev1_sda && d1) nstop1++;
            prev_scl = scl; prev_sda = sda; prev1_scl = s1; prev1_sda = d1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit s, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; wr0 = !s; wr1 = s;
        @(negedge clk);
        wr0 = 0; wr1 = 0;
    endtask

    task automatic rd(input bit s, input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = s ? rdata1 : rdata0;
    endtask

    task automatic wait_idle(input bit s);
        logic [15:0] v;
        int n;
        n = 0;
        do begin
            rd(s, 3'd3, v); n++;
        end while (v[0] && n < 5000);
    endtask

    task automatic clr_mon();
        nstart = 0; nstop = 0; nbytes = 0; bad_lo = 0; bad_hi = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(8 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        clr_mon(); nstop1 = 0; tchk = 0; slv_nread = 0; slv_base = 0;
        bitc = 0; byte_no = 0; rw = 0; shreg = 0; seen_st = 1; lo_len = 0; hi_len = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        rd(0, 3'd0, v); chk("R10 ctrl after reset", v, 16'h0000);
        rd(0, 3'd3, v); chk("R11 status after reset", v, 16'h0004);
        rd(0, 3'd2, v); chk("R7 raw after reset", v, 16'h0000);
        chk("R2 lines released after reset", {scl_low0, sda_low0}, 2'b00);

        // R1 R2 R3 sweep of SCL timing with three-byte writes
        for (int h = 2; h <= 4; h++) begin
            for (int l = 2; l <= 4; l++) begin
                logic [7:0] d1, d2;
                d1 = 8'((h * 53 + l * 17 + 29) & 255);
                d2 = 8'((h * 53 + l * 17 + 58) & 255);
                wr(0, 3'd4, 16'(h)); wr(0, 3'd5, 16'(l));
                hexp = h; lexp = l; tchk = 1; clr_mon();
                wr(0, 3'd0, 16'h0001);
                wr(0, 3'd1, 16'h00A0);
                wr(0, 3'd1, {8'h00, d1});
                wr(0, 3'd1, {6'd0, 2'b10, d2});
                wait_idle(0);
                chk("R2 one START", nstart, 1);
                chk("R2 one STOP", nstop, 1);
                chk("R1 byte count", nbytes, 3);
                chk("R1 address byte", byte_log[0], 8'hA0);
                chk("R1 first data byte", byte_log[1], d1);
                chk("R1 second data byte", byte_log[2], d2);
                chk("R3 low times", bad_lo, 0);
                chk("R3 high times", bad_hi, 0);
                rd(0, 3'd3, v); chk("R11 idle and empty", v, 16'h0004);
            end
        end

        // R5 read with ACK then NACK
        wr(0, 3'd4, 16'd3); wr(0, 3'd5, 16'd3); hexp = 3; lexp = 3;
        slv_nread = 2; slv_base = 8'hC5; clr_mon();
        wr(0, 3'd1, 16'h00A1);
        wr(0, 3'd1, 16'h0100);
        wr(0, 3'd1, 16'h0300);
        wait_idle(0);
        chk("R5 first read byte", byte_log[1], 8'hC5);
        chk("R5 master ACK", ack_log[1], 1'b0);
        chk("R5 second read byte", byte_log[2], 8'hD8);
        chk("R5 master NACK on stop", ack_log[2], 1'b1);
        rd(0, 3'd6, v); chk("R5 receive register", v, 16'h00D8);
        chk("R3 low times in read", bad_lo, 0);

        // R6 repeated START
        clr_mon();
        wr(0, 3'd1, 16'h00A0);
        wr(0, 3'd1, 16'h003C);
        wr(0, 3'd1, 16'h04A2);
        wr(0, 3'd1, 16'h0277);
        wait_idle(0);
        chk("R6 START count", nstart, 2);
        chk("R6 single STOP", nstop, 1);
        chk("R6 address after restart", byte_log[2], 8'hA2);
        chk("R6 last byte", byte_log[3], 8'h77);
        chk("R3 high times around restart", bad_hi, 0);

        // R7 R8 R10 hold, refused disable, resume
        tchk = 0; clr_mon();
        wr(0, 3'd1, 16'h00A0);
        n = 0;
        do begin rd(0, 3'd2, v); n++; end while (!v[13] && n < 2000);
        chk("R7 hold flag", v[13], 1'b1);
        repeat (50) @(negedge clk);
        chk("R7 SCL held low", scl_low0, 1'b1);
        chk("R7 no STOP while held", nstop, 0);
        rd(0, 3'd3, v); chk("R7 activity while held", v[0], 1'b1);
        wr(0, 3'd0, 16'h0000);
        rd(0, 3'd0, v); chk("R10 disable refused while held", v[0], 1'b1);
        wr(0, 3'd1, 16'h025A);
        n = 0;
        while (scl_low0 && n < 100) begin n++; @(negedge clk); end
        chk("R8 cycles to SCL release", n, 4);
        wait_idle(0);
        chk("R8 resumed byte", byte_log[1], 8'h5A);
        chk("R8 STOP after resume", nstop, 1);
        rd(0, 3'd2, v); chk("R7 hold flag gone", v[13], 1'b0);

        // R9 zero-count read leaves the bus held; abort recovers
        clr_mon(); slv_nread = 1; slv_base = 8'h00;
        wr(0, 3'd1, 16'h00A1);
        wr(0, 3'd1, 16'h0100);
        n = 0;
        do begin rd(0, 3'd2, v); n++; end while (!v[13] && n < 2000);
        chk("R7 hold after zero count", v[13], 1'b1);
        rd(0, 3'd6, v); chk("R5 zero count byte", v, 16'h0000);
        wr(0, 3'd0, 16'h0003);
        n = 0;
        do begin rd(0, 3'd0, v); n++; end while (v[1] && n < 2000);
        chk("R9 abort bit self-clears", v[1], 1'b0);
        chk("R9 STOP on abort", nstop, 1);
        rd(0, 3'd2, v); chk("R9 abort flag", v, 16'h0040);
        rd(0, 3'd3, v); chk("R9 idle and empty", v, 16'h0004);
        chk("R9 lines released", {scl_low0, sda_low0}, 2'b00);
        wr(0, 3'd0, 16'h0000);
        rd(0, 3'd0, v); chk("R10 disable when idle", v, 16'h0000);

        // R13 clear flag; R10 no start while disabled; R9 idle abort flushes
        wr(0, 3'd2, 16'h0040);
        rd(0, 3'd2, v); chk("R13 abort flag cleared", v, 16'h0000);
        clr_mon();
        wr(0, 3'd1, 16'h00A0);
        wr(0, 3'd1, 16'h0211);
        repeat (30) @(negedge clk);
        rd(0, 3'd3, v); chk("R10 queued but no start", v, 16'h0000);
        chk("R10 no START while disabled", nstart, 0);
        wr(0, 3'd0, 16'h0002);
        rd(0, 3'd0, v); chk("R9 idle abort done", v, 16'h0000);
        rd(0, 3'd3, v); chk("R9 queue flushed", v, 16'h0004);
        rd(0, 3'd2, v); chk("R9 flag on idle abort", v, 16'h0040);
        chk("R9 no bus activity", nstart, 0);

        // R12 hold option off: automatic STOP, flag never set
        wr(1, 3'd4, 16'd2); wr(1, 3'd5, 16'd2);
        wr(1, 3'd0, 16'h0001);
        wr(1, 3'd1, 16'h00A0);
        begin
            bit saw;
            saw = 0;
            for (int i = 0; i < 400; i++) begin
                rd(1, 3'd2, v);
                if (v[13]) saw = 1;
            end
            chk("R12 hold flag never set", saw, 1'b0);
        end
        rd(1, 3'd3, v); chk("R12 idle after auto STOP", v, 16'h0004);
        chk("R12 STOP issued", nstop1, 1);
        chk("R12 lines released", {scl_low1, sda_low1}, 2'b00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule